// File: doc/BRIEF.md
# Conversion and Calibration Sequencer

This block paces the back end of a delta-sigma converter from the master oscillator clock. It decides when each output word is ready, and it steps the datapath through offset and gain calibration steps. A request for one conversion, or a level that asks for continuous conversions, starts word timing. The length of each word comes from a 3-bit rate code. A 3-bit calibration code, loaded with a strobe, starts one or two calibration steps. At the end of every step the sequencer pulses a step-done strobe in place of real filter data. A sticky done flag reports that a conversion or a whole calibration has finished.

The length of a step is counted in master-clock cycles. The first conversion after a start pays a fixed settling surcharge. Continuous conversions after the first do not pay it, and neither do calibration steps. After reset the block stays in a boot state until a start-up timer expires, and it ignores every request while it waits.

States: `ST_BOOT` (start-up wait), `ST_IDLE`, `ST_CONV` (one output word), `ST_CAL_OFS` (offset step) and `ST_CAL_GAIN` (gain step). Transitions:
- boot→idle when the start-up timer expires.
- idle→cal-offset on a valid code whose first step is offset (001, 011, 101).
- idle→cal-gain on a gain-only code (010, 110).
- idle→conv on a single request or on continuous enable.
- conv→conv at a word end while continuous enable is high.
- conv→idle at a word end otherwise.
- cal-offset→cal-gain at the step end when the code is 011.
- cal-offset→idle at the step end for the other offset codes.
- cal-gain→idle at the step end.

Top module: `conv_cal_seq`

## Requirements
- R1: The rate code selects the cycles per word: 0→2182, 1→1090, 2→546, 3→266, 4→194, 5→162, 6→8722, 7→4362.
- R2: A conversion started from idle lasts the selected count plus 7 cycles. Each continuous conversion after it lasts exactly the selected count. `step_done` is high for one cycle in the last cycle of each step.
- R3: A single request runs one conversion and then returns to idle. Single requests and calibration loads that arrive while a step is running are ignored.
- R4: While `cont_en` is high, conversions follow each other with no gap. If `cont_en` is low at a word end, the sequencer returns to idle after that word.
- R5: A change of `rate_sel` during a step takes effect only at the next step boundary.
- R6: In idle, `cal_load` with code 001, 010, 101 or 110 runs one step lasting the selected count, with no surcharge. A calibration load wins over a conversion request in the same cycle. `cal_step` shows 1 for a self offset step, 2 for a self gain step, 3 for a system offset step, 4 for a system gain step, and 0 otherwise.
- R7: Code 011 runs a self offset step and then a self gain step, each lasting the selected count. The done flag is not set between the two steps.
- R8: `cal_ctrl` holds the accepted code while a calibration runs. In the cycle after the last step, `cal_ctrl` shows 000 and the done flag is 1.
- R9: Codes 000, 100 and 111 do nothing: no step is run, `cal_ctrl` stays 000 and the done flag keeps its value.
- R10: `ready` rises exactly 1024 clock edges after reset is released. Requests made before then are ignored.
- R11: The done flag is set at the end of every conversion and at the end of every calibration. `flag_clr` clears it. If both happen in the same cycle, the set wins.
- R12: During reset, `ready`, `step_done`, `cal_step`, `cal_ctrl` and `done_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| single_req | input | 1 | Request one conversion (sampled in idle) |
| cont_en | input | 1 | Level: run conversions continuously |
| rate_sel | input | 3 | Word-rate code |
| cal_load | input | 1 | Strobe that loads `cal_code` |
| cal_code | input | 3 | Calibration-control code |
| flag_clr | input | 1 | Clears the done flag |
| ready | output | 1 | Start-up wait is over |
| step_done | output | 1 | One-cycle pulse in the last cycle of each step |
| cal_step | output | 3 | Calibration step select for the datapath |
| cal_ctrl | output | 3 | Active calibration-control code, 000 when none |
| done_flag | output | 1 | Sticky completion flag |

## Verification
Assertions check, on every cycle, several local rules of the calibration sequence. A finished gain step always leaves the code at 000 with the done flag set. A finished offset step under code 011 always hands over to the self gain step. Unused codes leave the state untouched. The done flag only rises just after a step-done strobe. `ready` never falls once it has risen. The exact cycle counts can only be shown by the bench's scenarios. These cover each rate code, the first-word surcharge, the continuous spacing, a rate change in mid-word and the boot delay. The scenarios also show that requests arriving while the sequencer is busy leave no trace at the outputs.

// File: rtl/seq_pkg.sv
package seq_pkg;

    localparam int SEQ_TMR_W = 14;

    typedef enum logic [2:0] {
        ST_BOOT     = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CONV     = 3'd2,
        ST_CAL_OFS  = 3'd3,
        ST_CAL_GAIN = 3'd4
    } seq_state_t;

    typedef enum logic [2:0] {
        CS_NONE      = 3'd0,
        CS_SELF_OFS  = 3'd1,
        CS_SELF_GAIN = 3'd2,
        CS_SYS_OFS   = 3'd3,
        CS_SYS_GAIN  = 3'd4
    } cal_step_t;

    localparam logic [2:0] CC_NONE      = 3'b000;
    localparam logic [2:0] CC_SELF_OFS  = 3'b001;
    localparam logic [2:0] CC_SELF_GAIN = 3'b010;
    localparam logic [2:0] CC_SELF_BOTH = 3'b011;
    localparam logic [2:0] CC_SYS_OFS   = 3'b101;
    localparam logic [2:0] CC_SYS_GAIN  = 3'b110;

    // Master-clock cycles per output word for each rate code.
    function automatic logic [SEQ_TMR_W-1:0] rate_cycles(input logic [2:0] code);
        logic [SEQ_TMR_W-1:0] n;
        unique case (code)
            3'd0:    n = 14'd2182;
            3'd1:    n = 14'd1090;
            3'd2:    n = 14'd546;
            3'd3:    n = 14'd266;
            3'd4:    n = 14'd194;
            3'd5:    n = 14'd162;
            3'd6:    n = 14'd8722;
            default: n = 14'd4362;
        endcase
        return n;
    endfunction

    function automatic logic cal_code_valid(input logic [2:0] code);
        return (code == CC_SELF_OFS) || (code == CC_SELF_GAIN) ||
               (code == CC_SELF_BOTH) || (code == CC_SYS_OFS) ||
               (code == CC_SYS_GAIN);
    endfunction

    function automatic logic cal_starts_offset(input logic [2:0] code);
        return (code == CC_SELF_OFS) || (code == CC_SELF_BOTH) ||
               (code == CC_SYS_OFS);
    endfunction

endpackage

// File: rtl/seq_startup.sv
module seq_startup #(
    parameter int CYCLES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_BOOT_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o); // R10

endmodule

// File: rtl/seq_rate_map.sv
module seq_rate_map
    import seq_pkg::*;
#(
    parameter int TMR_W       = SEQ_TMR_W,
    parameter int FIRST_EXTRA = 7
) (
    input  logic [2:0]       rate_i,
    input  logic             first_i,
    output logic [TMR_W-1:0] len_o
);
    logic [TMR_W-1:0] base;
    logic [TMR_W-1:0] extra;

    always_comb begin
        base  = TMR_W'(rate_cycles(rate_i));
        extra = first_i ? TMR_W'(FIRST_EXTRA) : '0;
        len_o = base + extra;
    end

endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
    parameter int TMR_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] len_i,
    input  logic             run_i,
    output logic             tick_o
);
    logic [TMR_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= len_i - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_LOAD_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (len_i != '0)); // R1

    AST_LOAD_STARTS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && len_i > 1) |=> !tick_o); // R2

endmodule

// File: rtl/conv_cal_seq.sv
module conv_cal_seq
    import seq_pkg::*;
#(
    parameter int STARTUP_CYCLES = 1024,
    parameter int FIRST_EXTRA    = 7,
    parameter int TMR_W          = SEQ_TMR_W
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       single_req,
    input  logic       cont_en,
    input  logic [2:0] rate_sel,
    input  logic       cal_load,
    input  logic [2:0] cal_code,
    input  logic       flag_clr,
    output logic       ready,
    output logic       step_done,
    output logic [2:0] cal_step,
    output logic [2:0] cal_ctrl,
    output logic       done_flag
);
    seq_state_t       state_q, state_d;
    logic [2:0]       ctrl_q, ctrl_d;
    logic             done_q, done_d;
    logic             boot_done;
    logic             tmr_load, tmr_first, tmr_tick, tmr_run;
    logic             finish;
    logic [TMR_W-1:0] tmr_len;

    seq_startup #(.CYCLES(STARTUP_CYCLES)) u_startup (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (boot_done)
    );

    seq_rate_map #(.TMR_W(TMR_W), .FIRST_EXTRA(FIRST_EXTRA)) u_rate_map (
        .rate_i  (rate_sel),
        .first_i (tmr_first),
        .len_o   (tmr_len)
    );

    seq_step_timer #(.TMR_W(TMR_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .len_i  (tmr_len),
        .run_i  (tmr_run),
        .tick_o (tmr_tick)
    );

    assign tmr_run = (state_q == ST_CONV) || (state_q == ST_CAL_OFS) ||
                     (state_q == ST_CAL_GAIN);

    // Next-state and step-control decode.
    always_comb begin
        state_d   = state_q;
        ctrl_d    = ctrl_q;
        tmr_load  = 1'b0;
        tmr_first = 1'b0;
        finish    = 1'b0;
        unique case (state_q)
            ST_BOOT: begin
                if (boot_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (cal_load && cal_code_valid(cal_code)) begin
                    tmr_load = 1'b1;
                    ctrl_d   = cal_code;
                    state_d  = cal_starts_offset(cal_code) ? ST_CAL_OFS : ST_CAL_GAIN;
                end else if (single_req || cont_en) begin
                    tmr_load  = 1'b1;
                    tmr_first = 1'b1;
                    state_d   = ST_CONV;
                end
            end
            ST_CONV: begin
                if (tmr_tick) begin
                    finish = 1'b1;
                    if (cont_en) begin
                        tmr_load = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CAL_OFS: begin
                if (tmr_tick) begin
                    if (ctrl_q == CC_SELF_BOTH) begin
                        tmr_load = 1'b1;
                        state_d  = ST_CAL_GAIN;
                    end else begin
                        finish  = 1'b1;
                        ctrl_d  = CC_NONE;
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_CAL_GAIN: begin
                if (tmr_tick) begin
                    finish  = 1'b1;
                    ctrl_d  = CC_NONE;
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
                ctrl_d  = CC_NONE;
            end
        endcase
        done_d = finish ? 1'b1 : (flag_clr ? 1'b0 : done_q);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            ctrl_q  <= CC_NONE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ctrl_q  <= ctrl_d;
            done_q  <= done_d;
        end
    end

    // Outputs.
    always_comb begin
        ready     = (state_q != ST_BOOT);
        step_done = tmr_tick;
        cal_ctrl  = ctrl_q;
        done_flag = done_q;
        unique case (state_q)
            ST_CAL_OFS:  cal_step = (ctrl_q == CC_SYS_OFS)  ? CS_SYS_OFS  : CS_SELF_OFS;
            ST_CAL_GAIN: cal_step = (ctrl_q == CC_SYS_GAIN) ? CS_SYS_GAIN : CS_SELF_GAIN;
            default:     cal_step = CS_NONE;
        endcase
    end

    AST_CAL_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAL_GAIN && tmr_tick) |=> (cal_ctrl == CC_NONE && done_flag)); // R8

    AST_COMBO_CHAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAL_OFS && tmr_tick && ctrl_q == CC_SELF_BOTH)
        |=> (cal_step == CS_SELF_GAIN && cal_ctrl == CC_SELF_BOTH)); // R7

    AST_UNUSED_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cal_load && (cal_code == 3'b100 || cal_code == 3'b111)
         && !single_req && !cont_en && !flag_clr)
        |=> (state_q == ST_IDLE && cal_ctrl == CC_NONE && done_flag == $past(done_flag))); // R9

    AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(step_done)); // R11

    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R10

endmodule

// File: tb/conv_cal_seq_bench.sv
module conv_cal_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       single_req, cont_en, cal_load, flag_clr;
    logic [2:0] rate_sel, cal_code;
    logic       ready, step_done, done_flag;
    logic [2:0] cal_step, cal_ctrl;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    conv_cal_seq u_conv_cal_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .single_req (single_req),
        .cont_en    (cont_en),
        .rate_sel   (rate_sel),
        .cal_load   (cal_load),
        .cal_code   (cal_code),
        .flag_clr   (flag_clr),
        .ready      (ready),
        .step_done  (step_done),
        .cal_step   (cal_step),
        .cal_ctrl   (cal_ctrl),
        .done_flag  (done_flag)
    );

    function automatic int exp_cycles(input int r);
        case (r)
            0: return 2182;
            1: return 1090;
            2: return 546;
            3: return 266;
            4: return 194;
            5: return 162;
            6: return 8722;
            default: return 4362;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick1();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cycles(input int k);
        for (int i = 0; i < k; i++) tick1();
    endtask

    // Counts edges until step_done is seen; one-cycle request pulses are dropped.
    task automatic wait_step(output int n, input int poke_at);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
            single_req = (n == poke_at);
            cal_load   = 1'b0;
        end while (!step_done && n < 20000);
    endtask

    task automatic quiet(input int k, output int strobes);
        strobes = 0;
        for (int i = 0; i < k; i++) begin
            tick1();
            if (step_done) strobes++;
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick1();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset_and_boot();
        int seen;
        rst_n = 1'b0;
        cycles(3);
        chk("R12 ready", int'(ready), 0);
        chk("R12 step_done", int'(step_done), 0);
        chk("R12 cal_step", int'(cal_step), 0);
        chk("R12 cal_ctrl", int'(cal_ctrl), 0);
        chk("R12 done_flag", int'(done_flag), 0);
        rst_n = 1'b1;
        seen  = 0;
        for (int k = 1; k <= 1024; k++) begin
            @(posedge clk);
            @(negedge clk);
            single_req = (k == 100);
            cal_load   = (k == 200);
            cal_code   = 3'b001;
            if (step_done) seen++;
            if (k == 1023) chk("R10 ready before expiry", int'(ready), 0);
            if (k == 1024) chk("R10 ready at expiry", int'(ready), 1);
        end
        cal_load = 1'b0;
        chk("R10 no step during boot", seen, 0);
        quiet(300, seen);
        chk("R10 early requests dropped", seen, 0);
        chk("R10 cal code not taken", int'(cal_ctrl), 0);
    endtask

    task automatic t_rate_sweep();
        int n;
        for (int r = 0; r < 8; r++) begin
            rate_sel = 3'(r);
            clear_flag();
            single_req = 1'b1;
            wait_step(n, 0);
            chk($sformatf("R1 R2 first word rate %0d", r), n, exp_cycles(r) + 7);
            chk("R11 flag low at strobe", int'(done_flag), 0);
            tick1();
            chk("R11 flag set after word", int'(done_flag), 1);
        end
    endtask

    task automatic t_single_busy();
        int n, s;
        rate_sel   = 3'd5;
        single_req = 1'b1;
        wait_step(n, 50);
        chk("R3 single word length", n, 169);
        quiet(500, s);
        chk("R3 busy request ignored, back to idle", s, 0);
    endtask

    task automatic t_continuous();
        int n, s;
        rate_sel = 3'd4;
        cont_en  = 1'b1;
        wait_step(n, 0);
        chk("R2 continuous first word", n, 201);
        wait_step(n, 0);
        chk("R2 R4 second word", n, 194);
        wait_step(n, 0);
        chk("R4 third word", n, 194);
        cycles(10);
        cont_en = 1'b0;
        wait_step(n, 0);
        chk("R4 current word finishes", n, 184);
        quiet(400, s);
        chk("R4 stops after enable drops", s, 0);
    endtask

    task automatic t_rate_change();
        int n, s;
        rate_sel = 3'd5;
        cont_en  = 1'b1;
        wait_step(n, 0);
        chk("R5 first word", n, 169);
        cycles(20);
        rate_sel = 3'd3;
        wait_step(n, 0);
        chk("R5 running word keeps old rate", n, 142);
        wait_step(n, 0);
        chk("R5 new rate at boundary", n, 266);
        cycles(5);
        cont_en = 1'b0;
        wait_step(n, 0);
        chk("R5 last word", n, 261);
        quiet(300, s);
        chk("R4 idle after last word", s, 0);
    endtask

    task automatic t_cal_one(input logic [2:0] code, input int exp_step);
        int n;
        rate_sel = 3'd5;
        clear_flag();
        cal_code = code;
        cal_load = 1'b1;
        tick1();
        cal_load = 1'b0;
        chk($sformatf("R6 step select code %0d", code), int'(cal_step), exp_step);
        chk("R8 code held during cal", int'(cal_ctrl), int'(code));
        wait_step(n, 0);
        chk("R6 cal step length", n, 161);
        chk("R11 flag low at cal strobe", int'(done_flag), 0);
        tick1();
        chk("R8 code cleared", int'(cal_ctrl), 0);
        chk("R8 done set", int'(done_flag), 1);
        chk("R6 step select idle", int'(cal_step), 0);
    endtask

    task automatic t_cal_combo();
        int n;
        rate_sel = 3'd5;
        clear_flag();
        cal_code = 3'b011;
        cal_load = 1'b1;
        tick1();
        cal_load = 1'b0;
        chk("R7 offset first", int'(cal_step), 1);
        wait_step(n, 0);
        chk("R7 offset step length", n, 161);
        tick1();
        chk("R7 gain second", int'(cal_step), 2);
        chk("R7 no flag between steps", int'(done_flag), 0);
        chk("R7 code still held", int'(cal_ctrl), 3);
        wait_step(n, 0);
        chk("R7 gain step length", n, 161);
        tick1();
        chk("R8 combo code cleared", int'(cal_ctrl), 0);
        chk("R7 flag after gain", int'(done_flag), 1);
    endtask

    task automatic t_cal_priority();
        int n, s;
        rate_sel   = 3'd5;
        cal_code   = 3'b010;
        cal_load   = 1'b1;
        single_req = 1'b1;
        tick1();
        cal_load   = 1'b0;
        single_req = 1'b0;
        chk("R6 cal wins over conversion", int'(cal_step), 2);
        wait_step(n, 0);
        chk("R6 priority step length", n, 161);
        quiet(300, s);
        chk("R3 losing request not kept", s, 0);
    endtask

    task automatic t_unused(input logic [2:0] code, input int flag_before);
        int s;
        cal_code = code;
        cal_load = 1'b1;
        tick1();
        cal_load = 1'b0;
        chk($sformatf("R9 code %0d ctrl stays clear", code), int'(cal_ctrl), 0);
        chk("R9 no step select", int'(cal_step), 0);
        quiet(300, s);
        chk("R9 no step run", s, 0);
        chk("R9 flag unchanged", int'(done_flag), flag_before);
    endtask

    task automatic t_flag_priority();
        int n;
        rate_sel   = 3'd5;
        flag_clr   = 1'b1;
        single_req = 1'b1;
        wait_step(n, 0);
        chk("R2 word under clear", n, 169);
        tick1();
        chk("R11 set wins over clear", int'(done_flag), 1);
        tick1();
        chk("R11 clear takes effect", int'(done_flag), 0);
        flag_clr = 1'b0;
    endtask

    initial begin
        cycles(190000);
        checks++;
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n      = 1'b0;
        single_req = 1'b0;
        cont_en    = 1'b0;
        cal_load   = 1'b0;
        flag_clr   = 1'b0;
        rate_sel   = 3'd0;
        cal_code   = 3'd0;
        @(negedge clk);
        t_reset_and_boot();
        t_rate_sweep();
        t_single_busy();
        t_continuous();
        t_rate_change();
        t_cal_one(3'b001, 1);
        t_cal_one(3'b010, 2);
        t_cal_one(3'b101, 3);
        t_cal_one(3'b110, 4);
        t_cal_combo();
        t_cal_priority();
        t_unused(3'b100, 1);
        t_unused(3'b111, 1);
        t_unused(3'b000, 1);
        clear_flag();
        t_unused(3'b100, 0);
        t_flag_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule